// File: doc/BRIEF.md
# Fixed-Point Shift and Normalize Unit

This unit takes a 16-bit fixed-point operand and places it into a registered 32-bit result. The operand is first aligned to either the upper or lower half of a 32-bit word. It is then moved left or right by a signed amount, or by an amount the unit works out for itself. The unit also counts the redundant sign bits of the operand. It can shift the operand left by that count, so that the most significant bit differs from the sign bit, and it can shift a value back right by a supplied exponent.

A merge option combines each new shifted word with the result already held, using bitwise OR. With it, a value wider than 16 bits can be assembled from several passes: one pass aligned high, one aligned low. A separate register keeps the smallest exponent found over a run of operands. Block floating-point code reads that register to choose one common shift for the whole block.

The host issues one operation per cycle with `op_valid`. Outputs update on the clock edge that accepts the operation.

Top module: `shf_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0, `exp_out` becomes 0 and `blk_exp` becomes 15.
- R2: With `hi_sel`=1 the operand occupies result bits 31:16 and bits 15:0 are zero before shifting. With `hi_sel`=0 it occupies bits 15:0, and bits 31:16 are zero for code 0 and copies of operand bit 15 for codes 1, 2 and 3.
- R3: Code 0 (logical shift): a positive `amount` shifts left, and a negative one shifts right by its magnitude with zero fill. A magnitude of 32 or more gives zero.
- R4: Code 1 (arithmetic shift): positive amounts act as in R3. A negative amount shifts right filling with bit 31 of the aligned word, and a magnitude of 32 or more gives 32 copies of that bit.
- R5: Code 4 (derive exponent): `exp_out` takes the number of bits below bit 15 of `din` that equal bit 15 before the first differing bit (0 to 15). `result` and `blk_exp` are unchanged.
- R6: Code 2 (normalize): the aligned operand is shifted left by its own exponent as defined in R5, and `exp_out` takes that exponent.
- R7: Code 3 (denormalize): `amount` is read as an unsigned count 0 to 255, and the aligned operand is shifted right with bit-31 fill. Counts of 32 or more give 32 copies of bit 31.
- R8: Code 5 (block exponent): `exp_out` takes the exponent as in R5. `blk_exp` is replaced by it only when it is strictly smaller than the value held. `result` is unchanged.
- R9: For codes 0 to 3 with `or_mode`=1, the new `result` is the bitwise OR of the shifted word and the previous `result`.
- R10: When `op_valid` is low, or when the code is 6 or 7, `result`, `exp_out` and `blk_exp` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation is accepted at this edge |
| op | input | 3 | Operation code (see requirements) |
| din | input | 16 | Operand |
| amount | input | 8 | Shift amount, two's complement, or unsigned count for code 3 |
| hi_sel | input | 1 | Align operand to upper half when 1 |
| or_mode | input | 1 | Merge new shifted word into the held result |
| result | output | 32 | Registered 32-bit result |
| exp_out | output | 4 | Last derived exponent |
| blk_exp | output | 4 | Smallest exponent over the block |

## Verification
Two things can happen in one accepted cycle: a new shifted word and the OR-merge with the word already held. Normalize adds a third, since exponent derivation and the left shift it drives both occur in that same edge. The bench provokes these cases by issuing a high-aligned pass followed by a low-aligned pass with `or_mode` set, and by mixing `or_mode` randomly into normalize operations. It compares every `result`, `exp_out` and `blk_exp` against a bench model that keeps its own copy of the previous result and block exponent.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int SHF_DW = 16;
    localparam int SHF_AW = 8;

    typedef enum logic [2:0] {
        OP_LSH    = 3'd0,
        OP_ASH    = 3'd1,
        OP_NORM   = 3'd2,
        OP_DENORM = 3'd3,
        OP_EXP    = 3'd4,
        OP_BLKEXP = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } shf_op_e;

    // Steering for the barrel stage
    typedef struct packed {
        logic              left;
        logic              fill;
        logic [SHF_AW-1:0] mag;
    } shf_ctl_t;

    function automatic logic op_writes_result(shf_op_e o);
        return (o == OP_LSH) || (o == OP_ASH) || (o == OP_NORM) || (o == OP_DENORM);
    endfunction

    function automatic logic op_writes_exp(shf_op_e o);
        return (o == OP_NORM) || (o == OP_EXP) || (o == OP_BLKEXP);
    endfunction

    // Magnitude of a two's complement amount; -128 yields 128
    function automatic logic [SHF_AW-1:0] amt_mag(logic [SHF_AW-1:0] a);
        return a[SHF_AW-1] ? (~a + 1'b1) : a;
    endfunction

endpackage

// File: rtl/shf_align.sv
module shf_align #(
    parameter int DW = 16,
    localparam int RW = 2 * DW
) (
    input  logic [DW-1:0] din,
    input  logic          hi_sel,
    input  logic          sext,
    output logic [RW-1:0] aligned
);
    logic ext_bit;

    assign ext_bit = sext & din[DW-1];

    always_comb begin
        if (hi_sel) aligned = {din, {DW{1'b0}}};
        else        aligned = {{DW{ext_bit}}, din};
    end
endmodule

// File: rtl/shf_expdet.sv
module shf_expdet #(
    parameter int DW = 16,
    localparam int EW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    output logic [EW-1:0] exp_val
);
    logic run;

    always_comb begin
        exp_val = '0;
        run     = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (din[i] == din[DW-1])) exp_val = exp_val + EW'(1);
            else                              run     = 1'b0;
        end
    end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int RW = 32,
    parameter int AW = 8,
    localparam int SW = $clog2(RW)
) (
    input  logic [RW-1:0] data,
    input  logic          left,
    input  logic          fill,
    input  logic [AW-1:0] mag,
    output logic [RW-1:0] shifted
);
    logic [RW-1:0] stg [0:SW];
    logic          over;

    assign stg[0] = data;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stg[k+1] = !mag[k] ? stg[k] :
                          left    ? {stg[k][RW-1-D:0], {D{1'b0}}} :
                                    {{D{fill}}, stg[k][RW-1:D]};
    end

    assign over    = |mag[AW-1:SW];
    assign shifted = over ? (left ? '0 : {RW{fill}}) : stg[SW];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DW = SHF_DW,
    localparam int AW = SHF_AW,
    localparam int RW = 2 * DW,
    localparam int EW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] amount,
    input  logic          hi_sel,
    input  logic          or_mode,
    output logic [RW-1:0] result,
    output logic [EW-1:0] exp_out,
    output logic [EW-1:0] blk_exp
);
    shf_op_e       op_e;
    logic          sext;
    logic [RW-1:0] aligned;
    logic [EW-1:0] din_exp;
    shf_ctl_t      ctl;
    logic [RW-1:0] shifted;
    logic [RW-1:0] merged;

    logic [RW-1:0] result_q;
    logic [EW-1:0] exp_q;
    logic [EW-1:0] blk_q;

    assign op_e = shf_op_e'(op);
    assign sext = (op_e != OP_LSH);

    shf_align #(.DW(DW)) u_align (
        .din     (din),
        .hi_sel  (hi_sel),
        .sext    (sext),
        .aligned (aligned)
    );

    shf_expdet #(.DW(DW)) u_expdet (
        .din     (din),
        .exp_val (din_exp)
    );

    // Per-operation steering of the barrel stage
    always_comb begin
        ctl.left = 1'b1;
        ctl.fill = 1'b0;
        ctl.mag  = '0;
        unique case (op_e)
            OP_LSH: begin
                ctl.left = !amount[AW-1];
                ctl.mag  = amt_mag(amount);
            end
            OP_ASH: begin
                ctl.left = !amount[AW-1];
                ctl.fill = aligned[RW-1];
                ctl.mag  = amt_mag(amount);
            end
            OP_NORM: begin
                ctl.mag  = {{(AW-EW){1'b0}}, din_exp};
            end
            OP_DENORM: begin
                ctl.left = 1'b0;
                ctl.fill = aligned[RW-1];
                ctl.mag  = amount;
            end
            default: begin
                ctl.left = 1'b1;
            end
        endcase
    end

    shf_barrel #(.RW(RW), .AW(AW)) u_barrel (
        .data    (aligned),
        .left    (ctl.left),
        .fill    (ctl.fill),
        .mag     (ctl.mag),
        .shifted (shifted)
    );

    assign merged = or_mode ? (result_q | shifted) : shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            exp_q    <= '0;
            blk_q    <= EW'(DW - 1);
        end else if (op_valid) begin
            if (op_writes_result(op_e)) result_q <= merged;
            if (op_writes_exp(op_e))    exp_q    <= din_exp;
            if ((op_e == OP_BLKEXP) && (din_exp < blk_q)) blk_q <= din_exp;
        end
    end

    assign result  = result_q;
    assign exp_out = exp_q;
    assign blk_exp = blk_q;

    // Assertions
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (result == '0 && exp_out == '0 && blk_exp == EW'(DW - 1))); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op == 3'd6 || op == 3'd7)
        |=> ($stable(result) && $stable(exp_out) && $stable(blk_exp))); // R10

    AST_BLK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (blk_exp <= $past(blk_exp))); // R8

    AST_NORM_TOP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == 3'd2 && hi_sel && !or_mode && din != '0 && din != '1)
        |=> (result[RW-1] != result[RW-2])); // R6

    AST_OR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && or_mode && op <= 3'd3)
        |=> ((result & $past(result)) == $past(result))); // R9

    AST_EXP_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op == 3'd4 || op == 3'd5)) |=> $stable(result)); // R5
endmodule

// File: tb/tb_shf_unit.sv
module tb_shf_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] din = 16'h0;
    logic [7:0]  amount = 8'h0;
    logic        hi_sel = 1'b0;
    logic        or_mode = 1'b0;
    logic [31:0] result;
    logic [3:0]  exp_out;
    logic [3:0]  blk_exp;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_res;
    logic [3:0]  m_exp;
    logic [3:0]  m_blk;

    always #(CLK_P/2) clk = ~clk;

    shf_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .din(din),
        .amount(amount), .hi_sel(hi_sel), .or_mode(or_mode),
        .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
    );

    function automatic logic [31:0] m_align(logic [15:0] d, logic h, logic sx);
        if (h) return {d, 16'h0000};
        if (sx && d[15]) return {16'hFFFF, d};
        return {16'h0000, d};
    endfunction

    function automatic logic [3:0] m_expo(logic [15:0] d);
        int n = 0;
        int i = 14;
        while (i >= 0 && d[i] == d[15]) begin
            n++;
            i--;
        end
        return 4'(n);
    endfunction

    function automatic logic [31:0] m_left(logic [31:0] a, int m);
        logic [63:0] w;
        if (m >= 32) return 32'h0;
        w = {32'h0, a} << m;
        return w[31:0];
    endfunction

    function automatic logic [31:0] m_right(logic [31:0] a, int m, logic arith);
        logic signed [63:0] w;
        logic signed [63:0] r;
        w = (arith && a[31]) ? {32'hFFFF_FFFF, a} : {32'h0, a};
        if (m > 63) m = 63;
        r = w >>> m;
        return r[31:0];
    endfunction

    function automatic logic [31:0] m_shift(logic [2:0] o, logic [15:0] d,
                                            logic [7:0] a, logic h);
        logic [31:0] al;
        int sa;
        al = m_align(d, h, o != 3'd0);
        sa = int'($signed(a));
        case (o)
            3'd0:    return (sa < 0) ? m_right(al, -sa, 1'b0) : m_left(al, sa);
            3'd1:    return (sa < 0) ? m_right(al, -sa, 1'b1) : m_left(al, sa);
            3'd2:    return m_left(al, int'(m_expo(d)));
            default: return m_right(al, int'(a), 1'b1);
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R5";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_res = 32'h0; m_exp = 4'h0; m_blk = 4'hF;
        chk("R1", result, 32'h0);
        chk("R1", {28'h0, exp_out}, 32'h0);
        chk("R1", {28'h0, blk_exp}, 32'hF);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(logic v, logic [2:0] o, logic [15:0] d, logic [7:0] a,
                         logic h, logic om);
        logic [31:0] nw;
        string rt;
        string et;
        @(negedge clk);
        op_valid = v; op = o; din = d; amount = a; hi_sel = h; or_mode = om;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        rt = v ? tag_of(o) : "R10";
        et = rt;
        if (v && o <= 3'd3) begin
            nw = m_shift(o, d, a, h);
            m_res = om ? (m_res | nw) : nw;
            if (om) rt = "R9";
            else if (a == 8'h00 && o <= 3'd1) rt = "R2";
        end
        if (v && (o == 3'd2 || o == 3'd4 || o == 3'd5)) m_exp = m_expo(d);
        if (v && o == 3'd5 && m_expo(d) < m_blk) m_blk = m_expo(d);
        chk(rt, result, m_res);
        chk(et, {28'h0, exp_out}, {28'h0, m_exp});
        chk(v && o == 3'd5 ? "R8" : et, {28'h0, blk_exp}, {28'h0, m_blk});
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();

        // R2 alignment
        issue(1, 3'd0, 16'h8000, 8'd0, 1'b0, 1'b0);
        chk("R2", result, 32'h0000_8000);
        issue(1, 3'd1, 16'h8000, 8'd0, 1'b0, 1'b0);
        chk("R2", result, 32'hFFFF_8000);
        issue(1, 3'd0, 16'h8000, 8'd0, 1'b1, 1'b0);
        chk("R2", result, 32'h8000_0000);
        // R3 logical shifts
        issue(1, 3'd0, 16'h8001, 8'd4, 1'b0, 1'b0);
        chk("R3", result, 32'h0008_0010);
        issue(1, 3'd0, 16'h8000, 8'hFF, 1'b0, 1'b0);
        chk("R3", result, 32'h0000_4000);
        issue(1, 3'd0, 16'hFFFF, 8'd40, 1'b0, 1'b0);
        issue(1, 3'd0, 16'hFFFF, 8'hE0, 1'b1, 1'b0);
        chk("R3", result, 32'h0);
        // R4 arithmetic shifts
        issue(1, 3'd1, 16'h8000, 8'hFC, 1'b1, 1'b0);
        chk("R4", result, 32'hF800_0000);
        issue(1, 3'd1, 16'h8000, 8'h80, 1'b1, 1'b0);
        chk("R4", result, 32'hFFFF_FFFF);
        issue(1, 3'd1, 16'h4000, 8'hE0, 1'b1, 1'b0);
        // R5 exponent derive
        issue(1, 3'd4, 16'h0001, 8'd0, 1'b0, 1'b0);
        chk("R5", {28'h0, exp_out}, 32'd14);
        issue(1, 3'd4, 16'hFFFF, 8'd0, 1'b0, 1'b0);
        issue(1, 3'd4, 16'h4000, 8'd0, 1'b0, 1'b0);
        issue(1, 3'd4, 16'h0000, 8'd0, 1'b0, 1'b0);
        // R6 normalize
        issue(1, 3'd2, 16'h0003, 8'd0, 1'b1, 1'b0);
        chk("R6", result, 32'h6000_0000);
        issue(1, 3'd2, 16'hFFF0, 8'd0, 1'b0, 1'b0);
        // R7 denormalize
        issue(1, 3'd3, 16'h8000, 8'd3, 1'b1, 1'b0);
        chk("R7", result, 32'hF000_0000);
        issue(1, 3'd3, 16'h8000, 8'd200, 1'b1, 1'b0);
        issue(1, 3'd3, 16'h1234, 8'd32, 1'b0, 1'b0);
        // R8 block exponent
        issue(1, 3'd5, 16'h0100, 8'd0, 1'b0, 1'b0);
        chk("R8", {28'h0, blk_exp}, 32'd6);
        issue(1, 3'd5, 16'h0001, 8'd0, 1'b0, 1'b0);
        issue(1, 3'd5, 16'h2000, 8'd0, 1'b0, 1'b0);
        chk("R8", {28'h0, blk_exp}, 32'd1);
        // R9 multiword assembly
        issue(1, 3'd0, 16'h1234, 8'd0, 1'b1, 1'b0);
        issue(1, 3'd0, 16'h5678, 8'd0, 1'b0, 1'b1);
        chk("R9", result, 32'h1234_5678);
        // R10 idle and reserved codes
        issue(0, 3'd0, 16'hAAAA, 8'd3, 1'b1, 1'b0);
        issue(1, 3'd6, 16'h0001, 8'd1, 1'b0, 1'b0);
        issue(1, 3'd7, 16'h0001, 8'd1, 1'b1, 1'b1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [15:0] d;
            logic [7:0]  a;
            logic        v;
            d = 16'($urandom) >> ($urandom % 16);
            if ($urandom % 2) d = ~d;
            if ($urandom % 4 == 0) a = 8'($urandom);
            else a = 8'(int'($urandom % 41) - 20);
            v = ($urandom % 8) != 0;
            issue(v, 3'($urandom % 8), d, a, 1'($urandom), ($urandom % 3) == 0);
            if (n == 300) do_reset();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule